// File: doc/BRIEF.md
# SD Card Clock Divider and Data Timeout Unit

This unit derives the SD card clock from the base clock. An 8-bit one-hot code selects a division ratio of 2 to 256, and a zero code passes the base clock straight through. The card clock runs only when the internal clock is enabled and has settled and the card clock enable is set. The unit raises a status flag a fixed number of base cycles after the internal clock is enabled. If the card is pulled out while bus power is on, the unit cuts bus power and the card clock. They stay off until a full software reset.

The second function is a data timeout counter. It advances on a timeout clock enable strobe while a data transfer is active. Every data-activity strobe restarts it. It fires a one-cycle error pulse after 2^(TMO_BASE+N) strobes, where N is a 4-bit exponent. The full-reset and data-reset inputs clear the state that belongs to them.

Top module: `sd_clk_timer`

## Requirements
- R1: After reset, sd_clk, clk_stable, tmo_err and bus_power (with bus_pwr_req low) are all 0.
- R2: clk_stable goes to 1 after STABLE_CYC rising base-clock edges with int_clk_en held at 1. It goes to 0 in the same cycle that int_clk_en drops.
- R3: A div_code with only bit k set (0x01 up to 0x80) gives an sd_clk period of 2^(k+1) base cycles with equal high and low phases.
- R4: div_code 0x00 passes the base clock through to sd_clk.
- R5: A non-zero div_code with more than one bit set acts like the one-hot code of its highest set bit. For example, 0x06 divides by 8.
- R6: sd_clk is held at 0 unless int_clk_en, clk_stable and sd_clk_en are all 1 and no removal shutdown is latched.
- R7: A change of div_code while sd_clk is high does not shorten that high phase. The new ratio takes effect from the following low phase.
- R8: With xfer_active at 1, tmo_err pulses for exactly one cycle after 2^(TMO_BASE+N) tmo_tick strobes, where N = tmo_exp. The counter then starts again from zero.
- R9: tmo_exp = 15 is reserved and acts as N = 14.
- R10: The timeout count restarts on dat_strobe and on srst_dat, and is held at zero while xfer_active is 0. No tmo_err occurs while xfer_active is 0.
- R11: A falling card_in while bus_power is 1 forces bus_power and sd_clk to 0 from the next cycle on, even if the card is re-inserted.
- R12: srst_all clears the removal shutdown, clk_stable (which then settles again) and the timeout count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst_all | input | 1 | Synchronous full software reset |
| srst_dat | input | 1 | Synchronous data-path software reset |
| int_clk_en | input | 1 | Internal clock enable |
| sd_clk_en | input | 1 | Card clock enable |
| div_code | input | 8 | One-hot divider select, 0 = pass-through |
| card_in | input | 1 | Card present level |
| bus_pwr_req | input | 1 | Requested card bus power |
| tmo_tick | input | 1 | Timeout clock enable strobe |
| tmo_exp | input | 4 | Timeout exponent N |
| xfer_active | input | 1 | Data transfer in progress |
| dat_strobe | input | 1 | Data activity, restarts the timeout |
| sd_clk | output | 1 | Card clock |
| clk_stable | output | 1 | Internal clock settled |
| bus_power | output | 1 | Effective card bus power |
| tmo_err | output | 1 | Data timeout error pulse |

## Verification
A wrong divider counter or ratio register shows up within one card clock period as a shifted rising edge of sd_clk. A stale ratio applied in the middle of a high phase shortens that phase by a whole base cycle or more. A timeout counter that is off by one, or that is not cleared, moves the tmo_err pulse by whole tick strobes. The bench counts ticks exactly and detects this. A missed removal latch leaves bus_power high on the cycle after the card falls away.

// File: rtl/sd_clk_timer.sv
module sd_clk_timer #(
  parameter int STABLE_CYC = 8,
  parameter int TMO_BASE   = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst_all,
  input  logic       srst_dat,
  input  logic       int_clk_en,
  input  logic       sd_clk_en,
  input  logic [7:0] div_code,
  input  logic       card_in,
  input  logic       bus_pwr_req,
  input  logic       tmo_tick,
  input  logic [3:0] tmo_exp,
  input  logic       xfer_active,
  input  logic       dat_strobe,
  output logic       sd_clk,
  output logic       clk_stable,
  output logic       bus_power,
  output logic       tmo_err
);
  localparam int SW = $clog2(STABLE_CYC + 1);
  localparam int CW = TMO_BASE + 15;

  logic [SW-1:0] stab_cnt;
  logic          stab_q, kill_q, card_q, run, run_n, div1_n, div_q;
  logic [3:0]    cur_l, new_l, neff;
  logic [6:0]    dcnt, hm1;
  logic [7:0]    half;
  logic [CW-1:0] tcnt, tlim;
  logic          tclr;

  assign clk_stable = stab_q & int_clk_en;
  assign bus_power  = bus_pwr_req & ~kill_q;
  assign run        = clk_stable & sd_clk_en & ~kill_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stab_cnt <= '0;
      stab_q   <= 1'b0;
    end else if (srst_all || !int_clk_en) begin
      stab_cnt <= '0;
      stab_q   <= 1'b0;
    end else if (!stab_q) begin
      stab_cnt <= stab_cnt + 1'b1;
      if (stab_cnt == SW'(STABLE_CYC - 1)) stab_q <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      card_q <= 1'b0;
      kill_q <= 1'b0;
    end else begin
      card_q <= card_in;
      if (srst_all) kill_q <= 1'b0;
      else if (card_q && !card_in && bus_power) kill_q <= 1'b1;
    end

  always_comb begin
    new_l = 4'd0;
    for (int i = 0; i < 8; i++)
      if (div_code[i]) new_l = 4'(i + 1);
  end

  assign half = 8'd1 << (cur_l - 4'd1);
  assign hm1  = 7'(half - 8'd1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cur_l <= 4'd0;
      dcnt  <= '0;
      div_q <= 1'b0;
    end else if (srst_all) begin
      cur_l <= 4'd0;
      dcnt  <= '0;
      div_q <= 1'b0;
    end else if ((!run || !div_q) && new_l != cur_l) begin
      cur_l <= new_l;
      dcnt  <= '0;
      div_q <= 1'b0;
    end else if (!run || cur_l == 4'd0) begin
      dcnt  <= '0;
      div_q <= 1'b0;
    end else if (dcnt == hm1) begin
      dcnt  <= '0;
      div_q <= ~div_q;
    end else begin
      dcnt <= dcnt + 1'b1;
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      run_n  <= 1'b0;
      div1_n <= 1'b1;
    end else begin
      run_n  <= run;
      div1_n <= (cur_l == 4'd0);
    end

  assign sd_clk = div1_n ? (clk & run_n) : div_q;

  assign neff = (tmo_exp == 4'hF) ? 4'hE : tmo_exp;
  assign tlim = (CW'(1) << (TMO_BASE + 32'(neff))) - CW'(1);
  assign tclr = srst_all | srst_dat | dat_strobe | ~xfer_active;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tcnt    <= '0;
      tmo_err <= 1'b0;
    end else begin
      tmo_err <= 1'b0;
      if (tclr) tcnt <= '0;
      else if (tmo_tick) begin
        if (tcnt == tlim) begin
          tcnt    <= '0;
          tmo_err <= 1'b1;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
endmodule

// File: rtl/sd_clk_timer_chk.sv
module sd_clk_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic srst_all,
  input logic int_clk_en,
  input logic card_in,
  input logic bus_power,
  input logic xfer_active,
  input logic tmo_err,
  input logic clk_stable
);
  // R8
  tmo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |=> !tmo_err);
  // R10
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |=> !tmo_err);
  // R2
  stable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_stable) |-> $past(int_clk_en));
  // R11
  removal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_power && $fell(card_in) && !srst_all) |=> !bus_power);
  // R12
  full_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_all |=> (!clk_stable && !tmo_err));
endmodule

bind sd_clk_timer sd_clk_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .srst_all(srst_all), .int_clk_en(int_clk_en),
  .card_in(card_in), .bus_power(bus_power), .xfer_active(xfer_active),
  .tmo_err(tmo_err), .clk_stable(clk_stable)
);

// File: tb/sim_sd_clk_timer.sv
`timescale 1ns/1ps
module sim_sd_clk_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic srst_all = 0, srst_dat = 0, int_clk_en = 0, sd_clk_en = 0;
  logic [7:0] div_code = 8'h01;
  logic card_in = 0, bus_pwr_req = 0, tmo_tick = 0, xfer_active = 0, dat_strobe = 0;
  logic [3:0] tmo_exp = 0;
  logic sd_clk, clk_stable, bus_power, tmo_err;
  int cyc = 0, n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sd_clk_timer #(.STABLE_CYC(8), .TMO_BASE(2)) u0 (
    .clk(clk), .rst_n(rst_n), .srst_all(srst_all), .srst_dat(srst_dat),
    .int_clk_en(int_clk_en), .sd_clk_en(sd_clk_en), .div_code(div_code),
    .card_in(card_in), .bus_pwr_req(bus_pwr_req), .tmo_tick(tmo_tick),
    .tmo_exp(tmo_exp), .xfer_active(xfer_active), .dat_strobe(dat_strobe),
    .sd_clk(sd_clk), .clk_stable(clk_stable), .bus_power(bus_power), .tmo_err(tmo_err));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic next_rise(output int at);
    logic prev;
    prev = sd_clk;
    at = -1;
    for (int g = 0; g < 1000 && at < 0; g++) begin
      @(negedge clk); #1;
      if (sd_clk && !prev) at = cyc;
      prev = sd_clk;
    end
  endtask

  task automatic bring_up();
    @(negedge clk);
    int_clk_en = 1;
    step(10);
    sd_clk_en = 1;
  endtask

  task automatic t_reset();
    #1;
    check(sd_clk == 0, "R1 sd_clk", sd_clk, 0);
    check(clk_stable == 0, "R1 clk_stable", clk_stable, 0);
    check(tmo_err == 0, "R1 tmo_err", tmo_err, 0);
    check(bus_power == 0, "R1 bus_power", bus_power, 0);
  endtask

  task automatic t_stable();
    @(negedge clk);
    int_clk_en = 1;
    repeat (7) @(posedge clk);
    #1 check(clk_stable == 0, "R2 before settle", clk_stable, 0);
    @(posedge clk);
    #1 check(clk_stable == 1, "R2 after settle", clk_stable, 1);
    @(negedge clk);
    int_clk_en = 0;
    #1 check(clk_stable == 0, "R2 immediate drop", clk_stable, 0);
  endtask

  task automatic t_div(input logic [7:0] code, input int exp, input string req);
    int a, b, hi;
    @(negedge clk);
    div_code = code;
    next_rise(a); next_rise(a); next_rise(b);
    check(b - a == exp, req, b - a, exp);
    hi = 0;
    for (int g = 0; g < 600 && sd_clk; g++) begin hi++; @(negedge clk); #1; end
    check(hi == exp / 2, {req, " high phase"}, hi, exp / 2);
  endtask

  task automatic t_div1();
    @(negedge clk);
    div_code = 8'h00;
    step(4);
    @(posedge clk); #1 check(sd_clk == 1, "R4 high with base clock", sd_clk, 1);
    @(negedge clk); #1 check(sd_clk == 0, "R4 low with base clock", sd_clk, 0);
    @(posedge clk); #1 check(sd_clk == 1, "R4 second high", sd_clk, 1);
  endtask

  task automatic t_gate();
    int hi = 0;
    @(negedge clk);
    div_code = 8'h01;
    step(4);
    sd_clk_en = 0;
    step(1);
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1 if (sd_clk) hi++;
      @(negedge clk); #1 if (sd_clk) hi++;
    end
    check(hi == 0, "R6 gated with card clock enable off", hi, 0);
    sd_clk_en = 1;
  endtask

  task automatic t_glitch();
    int a, b, hi;
    @(negedge clk);
    div_code = 8'h02;
    next_rise(a); next_rise(a);
    div_code = 8'h08;
    hi = 0;
    @(negedge clk); #1;
    for (int g = 0; g < 100 && sd_clk; g++) begin hi++; @(negedge clk); #1; end
    check(hi == 1, "R7 high phase kept", hi, 1);
    next_rise(a); next_rise(b);
    check(b - a == 16, "R7 new ratio", b - a, 16);
  endtask

  task automatic count_to_err(input int every, output int ticks);
    bit seen = 0;
    ticks = 0;
    for (int i = 0; i < 150000 && !seen; i++) begin
      @(negedge clk); #1;
      if (tmo_err) seen = 1;
      else begin
        tmo_tick = (i % every == 0);
        if (tmo_tick) ticks++;
      end
    end
    tmo_tick = 0;
  endtask

  task automatic t_tmo(input logic [3:0] n, input int every, input int exp, input string req);
    int t;
    @(negedge clk);
    xfer_active = 0; tmo_exp = n;
    @(negedge clk);
    xfer_active = 1;
    count_to_err(every, t);
    check(t == exp, req, t, exp);
    @(negedge clk); #1 check(tmo_err == 0, {req, " single pulse"}, tmo_err, 0);
    count_to_err(every, t);
    check(t == exp, {req, " restart"}, t, exp);
    xfer_active = 0;
  endtask

  task automatic t_clear();
    int t, e;
    @(negedge clk);
    tmo_exp = 0; xfer_active = 1;
    tmo_tick = 1; step(3); tmo_tick = 0;
    dat_strobe = 1; step(1); dat_strobe = 0;
    count_to_err(1, t);
    check(t == 4, "R10 restart on data strobe", t, 4);
    @(negedge clk);
    tmo_tick = 1; step(3); tmo_tick = 0;
    srst_dat = 1; step(1); srst_dat = 0;
    count_to_err(1, t);
    check(t == 4, "R10 restart on data reset", t, 4);
    @(negedge clk);
    tmo_tick = 1; step(3);
    xfer_active = 0;
    e = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); #1 if (tmo_err) e++; end
    tmo_tick = 0;
    check(e == 0, "R10 no error while idle", e, 0);
    xfer_active = 1;
    count_to_err(1, t);
    check(t == 4, "R10 held clear while idle", t, 4);
    xfer_active = 0;
  endtask

  task automatic t_kill();
    int hi = 0;
    @(negedge clk);
    div_code = 8'h01; card_in = 1; bus_pwr_req = 1;
    step(4); #1;
    check(bus_power == 1, "R11 powered", bus_power, 1);
    card_in = 0;
    @(negedge clk); #1;
    check(bus_power == 0, "R11 power cut on removal", bus_power, 0);
    card_in = 1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); #1 if (sd_clk) hi++; end
    check(hi == 0, "R11 card clock stopped", hi, 0);
    check(bus_power == 0, "R11 latched after reinsert", bus_power, 0);
    srst_all = 1;
    @(negedge clk); srst_all = 0; #1;
    check(bus_power == 1, "R12 full reset clears shutdown", bus_power, 1);
    check(clk_stable == 0, "R12 full reset clears stable", clk_stable, 0);
    step(10); #1;
    check(clk_stable == 1, "R12 stable again", clk_stable, 1);
    bus_pwr_req = 0;
    @(negedge clk); card_in = 0;
    step(2); bus_pwr_req = 1; #1;
    check(bus_power == 1, "R11 unpowered removal ignored", bus_power, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_stable();
    bring_up();
    t_div(8'h01, 2, "R3 divide by 2");
    t_div(8'h04, 8, "R3 divide by 8");
    t_div(8'h80, 256, "R3 divide by 256");
    t_div(8'h06, 8, "R5 code 0x06");
    t_div(8'h30, 64, "R5 code 0x30");
    t_div1();
    t_gate();
    t_glitch();
    t_tmo(4'd0, 1, 4, "R8 exponent 0");
    t_tmo(4'd1, 2, 8, "R8 exponent 1 sparse ticks");
    t_tmo(4'd4, 1, 64, "R8 exponent 4");
    t_tmo(4'd15, 1, 65536, "R9 reserved exponent");
    t_clear();
    t_kill();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule